// File: doc/BRIEF.md
# Lane-Serialized SIMT Execute Sequencer

This block carries one already-decoded instruction through every lane of a warp using a single shared arithmetic unit. After accepting the instruction, it walks a lane counter upward from 0 to the last lane, one lane per clock. In each lane cycle it drives the read addresses of that lane's two source registers and takes the read data back in the same cycle. It then computes the lane's result and presents a write to that lane's destination register. Loads and stores make one data-memory word access per lane, and the byte address is turned into a word index.

Control flow is decided once per warp. A branch compares the operands of lane 0 only, and that outcome sets the warp's next PC. The cycle after the last lane, the block raises a one-cycle completion pulse. With that pulse it gives the branch outcome and the next PC. It also raises a stall request with a fixed length for memory instructions, or a halt request for HALT. The register file and data memory are outside the block and have combinational reads. Fetch, decode and warp scheduling are not part of this block.

Top module: `simt_lane_exec`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `stall_req_o`, `halt_req_o`, `rf_we_o` and `mem_we_o` are all low.
- R2: `start_i` is sampled only while idle. The instruction then occupies LANES consecutive cycles, one per lane, in ascending lane order from 0. `done_o` is high for exactly the following cycle, and the block is idle one cycle later. A `start_i` that arrives while busy is ignored.
- R3: A register address is {warp, lane, register}: warp in the top bit, lane in the next 3 bits, register index in the low 5 bits (9 bits total). Lane k's access uses lane field k.
- R4: The register-writing ALU opcodes are: ADD=1 (rs1+rs2), SUB=2 (rs1-rs2), AND=3, OR=4, XOR=5, ADDI=6 (rs1 plus the 16-bit immediate, sign-extended) and LANEID=12 (rd gets the lane index). Each lane writes only its own rd.
- R5: LOAD=7 writes the memory word at index ((rs1+imm) >> 2) mod 1024 into rd. An address beyond 4 KB wraps.
- R6: STORE=8 writes rs2 to the same word index and writes no register. When several lanes hit one word, the highest lane's value remains.
- R7: Together with `done_o`, LOAD and STORE raise `stall_req_o`. `stall_cycles_o` reads 4. Stall and halt are never high together.
- R8: HALT=15 raises `halt_req_o` together with `done_o` and writes neither registers nor memory.
- R9: BEQ=9, BNE=10 and BLT=11 (signed less-than) compare rs1 and rs2 of lane 0 only. Together with `done_o`, `br_taken_o` reports the result. `next_pc_o` is pc+imm (signed, in words) when taken and pc+1 otherwise, including for every non-branch opcode. Branches write no register.
- R10: Opcodes 0, 13 and 14 write neither registers nor memory but still run the full lane sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Instruction valid; taken when idle |
| op_i | input | 4 | Opcode |
| warp_i | input | 1 | Warp index |
| rd_i | input | 5 | Destination register |
| rs1_i | input | 5 | First source register |
| rs2_i | input | 5 | Second source register |
| imm_i | input | 16 | Signed immediate / branch offset |
| pc_i | input | 32 | Word PC of the instruction |
| busy_o | output | 1 | Instruction in flight, including the done cycle |
| rf_raddr_a_o | output | 9 | Register read address, rs1 of current lane |
| rf_raddr_b_o | output | 9 | Register read address, rs2 of current lane |
| rf_rdata_a_i | input | 32 | Read data for port A |
| rf_rdata_b_i | input | 32 | Read data for port B |
| rf_we_o | output | 1 | Register write enable |
| rf_waddr_o | output | 9 | Register write address |
| rf_wdata_o | output | 32 | Register write data |
| mem_addr_o | output | 10 | Data memory word index |
| mem_we_o | output | 1 | Data memory write enable |
| mem_wdata_o | output | 32 | Data memory write data |
| mem_rdata_i | input | 32 | Data memory read data |
| done_o | output | 1 | One-cycle completion pulse |
| stall_req_o | output | 1 | Warp stall request, with done |
| stall_cycles_o | output | 3 | Stall length |
| halt_req_o | output | 1 | Warp halt request, with done |
| br_taken_o | output | 1 | Branch outcome, with done |
| next_pc_o | output | 32 | Next word PC, valid with done |

## Verification
The bench uses the default parameters: eight lanes, two warps, 32 registers and a 1024-word memory. The memory is small enough that an immediate of 4096 makes the word index wrap back onto words that were just stored. With two warps, a wrong warp bit in the address ends up in the other warp's registers, where the full-array comparison finds it. Eight lanes give the branch tests room to have lane 0 disagree with lanes 1 to 7. They also let every lane store to one word, so only the last-lane-wins result can pass.

// File: rtl/simt_exec_pkg.sv
package simt_exec_pkg;

    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_ADD    = 4'd1,
        OP_SUB    = 4'd2,
        OP_AND    = 4'd3,
        OP_OR     = 4'd4,
        OP_XOR    = 4'd5,
        OP_ADDI   = 4'd6,
        OP_LOAD   = 4'd7,
        OP_STORE  = 4'd8,
        OP_BEQ    = 4'd9,
        OP_BNE    = 4'd10,
        OP_BLT    = 4'd11,
        OP_LANEID = 4'd12,
        OP_HALT   = 4'd15
    } opcode_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

endpackage

// File: rtl/simt_alu.sv
module simt_alu
    import simt_exec_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int IMM_W  = 16,
    parameter int LANE_W = 3
) (
    input  opcode_e             op,
    input  logic [XLEN-1:0]     a,
    input  logic [XLEN-1:0]     b,
    input  logic [IMM_W-1:0]    imm,
    input  logic [LANE_W-1:0]   lane,
    output logic [XLEN-1:0]     res,
    output logic                writes_rd
);
    logic [XLEN-1:0] imm_x;
    assign imm_x = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};

    always_comb begin
        res       = '0;
        writes_rd = 1'b1;
        unique case (op)
            OP_ADD:    res = a + b;
            OP_SUB:    res = a - b;
            OP_AND:    res = a & b;
            OP_OR:     res = a | b;
            OP_XOR:    res = a ^ b;
            OP_ADDI:   res = a + imm_x;
            OP_LANEID: res = XLEN'(lane);
            default:   writes_rd = 1'b0;
        endcase
    end
endmodule

// File: rtl/simt_agu.sv
module simt_agu #(
    parameter int XLEN    = 32,
    parameter int IMM_W   = 16,
    parameter int DADDR_W = 10
) (
    input  logic [XLEN-1:0]    base,
    input  logic [IMM_W-1:0]   imm,
    output logic [DADDR_W-1:0] word_idx
);
    logic [XLEN-1:0] byte_addr;
    logic            unused_addr_bits;

    assign byte_addr        = base + {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    assign word_idx         = byte_addr[DADDR_W+1:2];
    assign unused_addr_bits = ^{byte_addr[1:0], byte_addr[XLEN-1:DADDR_W+2]};
endmodule

// File: rtl/simt_branch.sv
module simt_branch
    import simt_exec_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    parameter int PC_W  = 32
) (
    input  opcode_e           op,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    input  logic [IMM_W-1:0]  imm,
    input  logic [PC_W-1:0]   pc,
    output logic              taken,
    output logic [PC_W-1:0]   next_pc
);
    logic [PC_W-1:0] offs;
    assign offs = {{(PC_W-IMM_W){imm[IMM_W-1]}}, imm};

    always_comb begin
        unique case (op)
            OP_BEQ:  taken = (a == b);
            OP_BNE:  taken = (a != b);
            OP_BLT:  taken = ($signed(a) < $signed(b));
            default: taken = 1'b0;
        endcase
        next_pc = taken ? (pc + offs) : (pc + PC_W'(1));
    end
endmodule

// File: rtl/simt_lane_exec.sv
module simt_lane_exec
    import simt_exec_pkg::*;
#(
    parameter  int LANES      = 8,
    parameter  int WARPS      = 2,
    parameter  int NREGS      = 32,
    parameter  int XLEN       = 32,
    parameter  int IMM_W      = 16,
    parameter  int PC_W       = 32,
    parameter  int DMEM_WORDS = 1024,
    parameter  int MEM_STALL  = 4,
    localparam int LANE_W     = $clog2(LANES),
    localparam int WARP_W     = (WARPS > 1) ? $clog2(WARPS) : 1,
    localparam int REG_W      = $clog2(NREGS),
    localparam int RF_AW      = WARP_W + LANE_W + REG_W,
    localparam int DADDR_W    = $clog2(DMEM_WORDS),
    localparam int STALL_W    = $clog2(MEM_STALL + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [3:0]         op_i,
    input  logic [WARP_W-1:0]  warp_i,
    input  logic [REG_W-1:0]   rd_i,
    input  logic [REG_W-1:0]   rs1_i,
    input  logic [REG_W-1:0]   rs2_i,
    input  logic [IMM_W-1:0]   imm_i,
    input  logic [PC_W-1:0]    pc_i,
    output logic               busy_o,
    output logic [RF_AW-1:0]   rf_raddr_a_o,
    output logic [RF_AW-1:0]   rf_raddr_b_o,
    input  logic [XLEN-1:0]    rf_rdata_a_i,
    input  logic [XLEN-1:0]    rf_rdata_b_i,
    output logic               rf_we_o,
    output logic [RF_AW-1:0]   rf_waddr_o,
    output logic [XLEN-1:0]    rf_wdata_o,
    output logic [DADDR_W-1:0] mem_addr_o,
    output logic               mem_we_o,
    output logic [XLEN-1:0]    mem_wdata_o,
    input  logic [XLEN-1:0]    mem_rdata_i,
    output logic               done_o,
    output logic               stall_req_o,
    output logic [STALL_W-1:0] stall_cycles_o,
    output logic               halt_req_o,
    output logic               br_taken_o,
    output logic [PC_W-1:0]    next_pc_o
);
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

    typedef struct packed {
        phase_e              phase;
        logic [LANE_W-1:0]   lane;
        opcode_e             op;
        logic [WARP_W-1:0]   warp;
        logic [REG_W-1:0]    rd;
        logic [REG_W-1:0]    rs1;
        logic [REG_W-1:0]    rs2;
        logic [IMM_W-1:0]    imm;
        logic [PC_W-1:0]     pc;
        logic                taken;
        logic [PC_W-1:0]     next_pc;
    } seq_t;

    seq_t q, d;

    logic [XLEN-1:0]    alu_res;
    logic               alu_wr;
    logic               br_taken;
    logic [PC_W-1:0]    br_next;
    logic [DADDR_W-1:0] word_idx;
    logic               in_run;
    logic               is_mem;

    simt_alu #(.XLEN(XLEN), .IMM_W(IMM_W), .LANE_W(LANE_W)) u_alu (
        .op(q.op), .a(rf_rdata_a_i), .b(rf_rdata_b_i), .imm(q.imm),
        .lane(q.lane), .res(alu_res), .writes_rd(alu_wr)
    );

    simt_agu #(.XLEN(XLEN), .IMM_W(IMM_W), .DADDR_W(DADDR_W)) u_agu (
        .base(rf_rdata_a_i), .imm(q.imm), .word_idx(word_idx)
    );

    simt_branch #(.XLEN(XLEN), .IMM_W(IMM_W), .PC_W(PC_W)) u_br (
        .op(q.op), .a(rf_rdata_a_i), .b(rf_rdata_b_i), .imm(q.imm),
        .pc(q.pc), .taken(br_taken), .next_pc(br_next)
    );

    always_comb begin
        d = q;
        unique case (q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    d.phase = PH_RUN;
                    d.lane  = '0;
                    d.op    = opcode_e'(op_i);
                    d.warp  = warp_i;
                    d.rd    = rd_i;
                    d.rs1   = rs1_i;
                    d.rs2   = rs2_i;
                    d.imm   = imm_i;
                    d.pc    = pc_i;
                end
            end
            PH_RUN: begin
                if (q.lane == '0) begin
                    d.taken   = br_taken;
                    d.next_pc = br_next;
                end
                if (q.lane == LAST_LANE) begin
                    d.phase = PH_DONE;
                    d.lane  = '0;
                end else begin
                    d.lane = q.lane + LANE_W'(1);
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, op: OP_NOP, default: '0};
        end else begin
            q <= d;
        end
    end

    assign in_run = (q.phase == PH_RUN);
    assign is_mem = (q.op == OP_LOAD) || (q.op == OP_STORE);

    assign busy_o         = (q.phase != PH_IDLE);
    assign rf_raddr_a_o   = {q.warp, q.lane, q.rs1};
    assign rf_raddr_b_o   = {q.warp, q.lane, q.rs2};
    assign rf_waddr_o     = {q.warp, q.lane, q.rd};
    assign rf_we_o        = in_run && (alu_wr || q.op == OP_LOAD);
    assign rf_wdata_o     = (q.op == OP_LOAD) ? mem_rdata_i : alu_res;
    assign mem_addr_o     = word_idx;
    assign mem_we_o       = in_run && (q.op == OP_STORE);
    assign mem_wdata_o    = rf_rdata_b_i;
    assign done_o         = (q.phase == PH_DONE);
    assign stall_req_o    = done_o && is_mem;
    assign stall_cycles_o = STALL_W'(MEM_STALL);
    assign halt_req_o     = done_o && (q.op == OP_HALT);
    assign br_taken_o     = done_o && q.taken;
    assign next_pc_o      = q.next_pc;
endmodule

// File: rtl/simt_lane_exec_chk.sv
module simt_lane_exec_chk #(
    parameter int LANE_W = 3,
    parameter int REG_W  = 5,
    parameter int RF_AW  = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             stall,
    input logic             halt,
    input logic             rf_we,
    input logic             mem_we,
    input logic [RF_AW-1:0] raddr
);
    logic [LANE_W-1:0] lane;
    logic              running;
    assign lane    = raddr[REG_W +: LANE_W];
    assign running = busy && !done;

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_idle_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    assert_lane_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (lane == '0));
    assert_lane_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running)) |-> (lane == $past(lane) + LANE_W'(1)));
    assert_rf_we_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> running);
    assert_store_no_rf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (running && !rf_we));
    assert_stall_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> done);
    assert_req_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stall, halt}));
    assert_halt_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> done);
endmodule

bind simt_lane_exec simt_lane_exec_chk #(
    .LANE_W(LANE_W), .REG_W(REG_W), .RF_AW(RF_AW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy_o), .done(done_o),
    .stall(stall_req_o), .halt(halt_req_o), .rf_we(rf_we_o),
    .mem_we(mem_we_o), .raddr(rf_raddr_a_o)
);

// File: tb/tb_simt_lane_exec.sv
module tb_simt_lane_exec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [0:0]  warp_i = '0;
    logic [4:0]  rd_i = '0, rs1_i = '0, rs2_i = '0;
    logic [15:0] imm_i = '0;
    logic [31:0] pc_i = '0;
    logic        busy_o, rf_we_o, mem_we_o, done_o, stall_req_o, halt_req_o, br_taken_o;
    logic [8:0]  rf_raddr_a_o, rf_raddr_b_o, rf_waddr_o;
    logic [31:0] rf_rdata_a_i, rf_rdata_b_i, rf_wdata_o, mem_wdata_o, mem_rdata_i, next_pc_o;
    logic [9:0]  mem_addr_o;
    logic [2:0]  stall_cycles_o;

    logic [31:0] rf [512];
    logic [31:0] mem [1024];
    logic [31:0] srf [512];
    logic [31:0] smem [1024];
    int checks = 0, errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    simt_lane_exec dut (.*);

    assign rf_rdata_a_i = rf[rf_raddr_a_o];
    assign rf_rdata_b_i = rf[rf_raddr_b_o];
    assign mem_rdata_i  = mem[mem_addr_o];

    always @(posedge clk) begin
        if (rf_we_o)  rf[rf_waddr_o]  <= rf_wdata_o;
        if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
    end

    function automatic int ra(int w, int l, int r);
        return w * 256 + l * 32 + r;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare_arrays(string req);
        int bad = 0, first = -1;
        for (int i = 0; i < 512; i++) if (rf[i] !== srf[i]) begin bad++; if (first < 0) first = i; end
        chk(bad == 0, req, "register array", (first < 0) ? 0 : rf[first], (first < 0) ? 0 : srf[first]);
        bad = 0; first = -1;
        for (int i = 0; i < 1024; i++) if (mem[i] !== smem[i]) begin bad++; if (first < 0) first = i; end
        chk(bad == 0, req, "memory array", (first < 0) ? 0 : mem[first], (first < 0) ? 0 : smem[first]);
    endtask

    task automatic issue(int op, int w, int rd, int rs1, int rs2, int imm, int pc, bit glitch, string req);
        logic [31:0] a, b, ix, exp_npc;
        bit exp_taken = 0;
        bit writes;
        ix = 32'(imm);
        for (int l = 0; l < 8; l++) begin
            a = srf[ra(w, l, rs1)];
            b = srf[ra(w, l, rs2)];
            if (l == 0) begin
                if (op == 9)  exp_taken = (a == b);
                if (op == 10) exp_taken = (a != b);
                if (op == 11) exp_taken = ($signed(a) < $signed(b));
            end
            case (op)
                1:  srf[ra(w, l, rd)] = a + b;
                2:  srf[ra(w, l, rd)] = a - b;
                3:  srf[ra(w, l, rd)] = a & b;
                4:  srf[ra(w, l, rd)] = a | b;
                5:  srf[ra(w, l, rd)] = a ^ b;
                6:  srf[ra(w, l, rd)] = a + ix;
                12: srf[ra(w, l, rd)] = 32'(l);
                7:  srf[ra(w, l, rd)] = smem[((a + ix) >> 2) % 1024];
                8:  smem[((a + ix) >> 2) % 1024] = b;
                default: ;
            endcase
        end
        exp_npc = exp_taken ? 32'(pc + imm) : 32'(pc + 1);
        writes = (op >= 1 && op <= 7) || op == 12;

        @(negedge clk);
        op_i = 4'(op); warp_i = 1'(w); rd_i = 5'(rd); rs1_i = 5'(rs1); rs2_i = 5'(rs2);
        imm_i = 16'(imm); pc_i = 32'(pc); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 8; k++) begin
            chk(busy_o && !done_o, "R2", $sformatf("lane %0d busy/!done", k), {busy_o, done_o}, 2'b10);
            chk(!stall_req_o && !halt_req_o, "R7", "no request mid-run", {stall_req_o, halt_req_o}, 0);
            chk(rf_we_o == writes, "R10", $sformatf("write enable lane %0d", k), rf_we_o, writes);
            if (writes)
                chk(rf_waddr_o == 9'(ra(w, k, rd)), "R3", $sformatf("write address lane %0d", k),
                    rf_waddr_o, ra(w, k, rd));
            if (glitch && k == 3) begin
                op_i = 4'd1; rd_i = 5'd30; rs1_i = 5'd1; rs2_i = 5'd1; start_i = 1'b1;
            end
            if (glitch && k == 4) start_i = 1'b0;
            @(negedge clk);
        end
        chk(done_o && busy_o, "R2", "done pulse", {busy_o, done_o}, 2'b11);
        chk(stall_req_o == (op == 7 || op == 8), "R7", "stall request", stall_req_o, (op == 7 || op == 8));
        chk(stall_cycles_o == 3'd4, "R7", "stall length", stall_cycles_o, 4);
        chk(halt_req_o == (op == 15), "R8", "halt request", halt_req_o, (op == 15));
        chk(br_taken_o == exp_taken, "R9", "branch outcome", br_taken_o, exp_taken);
        chk(next_pc_o == exp_npc, "R9", "next pc", next_pc_o, exp_npc);
        @(negedge clk);
        chk(!busy_o && !done_o, "R2", "idle after done", {busy_o, done_o}, 0);
        compare_arrays(req);
    endtask

    initial begin
        #100_000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) begin rf[i] = 32'(i) * 32'h9E3779B1; srf[i] = rf[i]; end
        for (int i = 0; i < 1024; i++) begin mem[i] = 32'(i * 3 + 7); smem[i] = mem[i]; end
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !stall_req_o && !halt_req_o && !rf_we_o && !mem_we_o, "R1",
            "reset outputs", {busy_o, done_o, stall_req_o, halt_req_o, rf_we_o, mem_we_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o, "R1", "idle after release", {busy_o, done_o}, 0);

        issue(12, 0, 5, 0, 0, 0, 10, 0, "R3");     // lane index into r5, warp 0
        issue(12, 1, 5, 0, 0, 0, 11, 0, "R3");     // same in warp 1
        issue(1, 1, 3, 1, 2, 0, 12, 0, "R4");
        issue(2, 0, 4, 7, 9, 0, 13, 0, "R4");
        issue(3, 1, 6, 8, 10, 0, 14, 0, "R4");
        issue(4, 0, 7, 11, 12, 0, 15, 0, "R4");
        issue(5, 1, 8, 13, 14, 0, 16, 0, "R4");
        issue(6, 0, 9, 15, 0, -300, 17, 0, "R4");
        issue(1, 0, 6, 5, 5, 0, 18, 0, "R4");      // r6 = 2*lane
        issue(1, 0, 6, 6, 6, 0, 19, 0, "R4");      // r6 = 4*lane
        issue(8, 0, 0, 6, 20, 256, 20, 0, "R6");   // words 64..71
        issue(7, 0, 21, 6, 0, 256, 21, 0, "R5");
        issue(7, 0, 22, 6, 0, 4096 + 256, 22, 0, "R5"); // wraps to 64..71
        issue(2, 0, 23, 5, 5, 0, 23, 0, "R4");     // r23 = 0
        issue(8, 0, 0, 23, 5, 8, 24, 0, "R6");     // all lanes to word 2, lane 7 wins
        issue(15, 0, 0, 0, 0, 0, 25, 0, "R8");
        issue(9, 0, 0, 5, 23, -5, 100, 0, "R9");   // lane 0 equal -> taken
        issue(10, 0, 0, 5, 23, -5, 100, 0, "R9");  // lane 0 equal -> not taken
        issue(11, 0, 0, 23, 5, 7, 40, 0, "R9");    // 0<0 false on lane 0
        issue(11, 0, 0, 9, 5, 7, 40, 0, "R9");
        issue(13, 1, 2, 1, 1, 0, 41, 0, "R10");
        issue(14, 0, 2, 1, 1, 0, 42, 0, "R10");
        issue(0, 1, 2, 1, 1, 0, 43, 0, "R10");
        issue(6, 1, 11, 5, 0, 1, 44, 1, "R2");     // start while busy ignored

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule